// File: doc/BRIEF.md
# Registered-Mode Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device running in its registered operating mode. An AND array supplies eight product terms. The cell ORs them, applies a selectable polarity and then drives the device pin in one of two forms. In the registered form, a D flip-flop captures the sum on the shared device clock. In the combinational form, the cell drives the pin directly and one product term acts as the pin's own tri-state enable.

All cells in registered mode share one clock input and one active-low output-enable input. These two inputs have no other use. Each cell chooses its form on its own, so a device can have any mix of registered outputs and combinational I/Os. The cell also returns a feedback signal to the array. In the registered form this is the inverted flip-flop output. In the combinational form it is the sensed pin value, so the pin can serve as an input.

The pin is modelled as three signals: the driven value, the drive enable and the sensed value.

Top module: `pld_reg_macrocell`

## Requirements
- R1: Unless the synchronous-mode bit is 0 and the AC0 bit is 1, the cell is inactive. In that state pin_oe, pin_o and fb_o are all 0.
- R2: On every rising clk edge while rst_n is high, the flip-flop loads the polarity-adjusted OR of all eight product terms. This happens whatever the mode bits and the enable input are. In the registered form (mode active, AC1=0), pin_o shows the flip-flop output.
- R3: Polarity bit 1 gives an active-high result: the result is 1 when any counted term is 1. Polarity bit 0 inverts that result. The same rule applies in both forms.
- R4: In the combinational form (mode active, AC1=1), pin_o in the same cycle is the polarity-adjusted OR of product terms 0 to 6 only. Term 7 has no effect on pin_o.
- R5: In the combinational form, pin_oe equals product term 7. Forcing term 7 to 0 makes the pin an input, and forcing it to 1 makes it an output.
- R6: In the registered form, pin_oe is 1 exactly when oe_n is 0. While oe_n is 1, the flip-flop keeps loading on each edge.
- R7: In the registered form, fb_o is the inverse of the flip-flop output.
- R8: In the combinational form, fb_o equals pin_i.
- R9: When rst_n is low at a rising clk edge, the flip-flop clears to 0.
- R10: oe_n has no effect on pin_oe or pin_o in the combinational form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock input shared by all registered cells |
| rst_n | input | 1 | Synchronous active-low reset of the flip-flop |
| oe_n | input | 1 | Common active-low output enable for registered outputs |
| cfg_sync | input | 1 | Synchronous-mode bit; must be 0 for registered mode |
| cfg_ac0 | input | 1 | Architecture bit AC0; must be 1 for registered mode |
| cfg_ac1 | input | 1 | Form select: 0 registered, 1 combinational I/O |
| cfg_pol | input | 1 | Polarity: 1 active high, 0 active low |
| pt_i | input | NUM_PT | Product terms from the AND array |
| pin_i | input | 1 | Value sensed on the device pin |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
The random part of the bench drives all sixteen combinations of the mode bits with random product-term vectors, enable values, pin values and occasional resets. This separates the inactive, registered and combinational forms, and shows whether term 7 is used as data or as the enable. Directed cases use product-term vectors where only term 7 is set, with both polarities. These distinguish the eight-term sum from the seven-term sum. A sequence that clocks in new data while the enable is off and then re-enables the pin shows that the flip-flop kept loading. A reset-state check confirms that the flip-flop clears, which shows as feedback 1 in the registered form.

// File: rtl/pld_mc_pkg.sv
// Package: shared types and the decoding of the mode bits for the output macrocell.
// Assumes: registered mode is selected only when sync = 0 and ac0 = 1.
package pld_mc_pkg;

    typedef enum logic [1:0] {
        CELL_OFF  = 2'd0,
        CELL_REG  = 2'd1,
        CELL_COMB = 2'd2
    } cell_form_e;

    // Maps the three architecture bits to the form the cell takes.
    function automatic cell_form_e decode_form(input logic sync, input logic ac0,
                                               input logic ac1);
        if (sync || !ac0) begin
            return CELL_OFF;
        end
        return ac1 ? CELL_COMB : CELL_REG;
    endfunction

endpackage

// File: rtl/mc_mode_decode.sv
// Module: mc_mode_decode
// Turns the architecture bits into the cell form.
// Assumes: the bits are static configuration, so the decoded form is purely combinational.
module mc_mode_decode
    import pld_mc_pkg::*;
(
    input  logic       sync_i,
    input  logic       ac0_i,
    input  logic       ac1_i,
    output cell_form_e form_o
);

    // Decode the form from the mode bits.
    always_comb begin
        form_o = decode_form(sync_i, ac0_i, ac1_i);
    end

endmodule

// File: rtl/mc_term_or.sv
// Module: mc_term_or
// ORs WIDTH product terms and applies the polarity (1 = active high).
// Assumes: WIDTH >= 1; the OR is built as an explicit chain so a synthesis tool can rebalance it.
module mc_term_or #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] terms_i,
    input  logic             pol_i,
    output logic             sum_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_or
            assign chain[i+1] = chain[i] | terms_i[i];
        end
    endgenerate

    // Polarity: invert the OR result when the cell is active low.
    always_comb begin
        sum_o = pol_i ? chain[WIDTH] : ~chain[WIDTH];
    end

endmodule

// File: rtl/mc_out_reg.sv
// Module: mc_out_reg
// D flip-flop on the common clock, with a synchronous active-low clear.
// Assumes: it loads on every edge; the output enable never holds it back.
module mc_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    // Capture the data input, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/pld_reg_macrocell.sv
// Module: pld_reg_macrocell
// One output cell of the device in registered mode. It is either a registered output on the
// shared clock and enable, or a combinational I/O whose last product term is the pin's enable.
// Assumes: NUM_PT >= 2; the pin is modelled as separate drive, enable and sense signals.
module pld_reg_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              cfg_sync,
    input  logic              cfg_ac0,
    input  logic              cfg_ac1,
    input  logic              cfg_pol,
    input  logic [NUM_PT-1:0] pt_i,
    input  logic              pin_i,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              fb_o
);

    localparam int DATA_PT_COMB = NUM_PT - 1;
    localparam int OE_PT_IDX    = NUM_PT - 1;

    cell_form_e form;
    logic       reg_d;
    logic       reg_q;
    logic       comb_d;

    mc_mode_decode u_decode (
        .sync_i (cfg_sync),
        .ac0_i  (cfg_ac0),
        .ac1_i  (cfg_ac1),
        .form_o (form)
    );

    mc_term_or #(.WIDTH(NUM_PT)) u_sum_reg (
        .terms_i (pt_i),
        .pol_i   (cfg_pol),
        .sum_o   (reg_d)
    );

    mc_term_or #(.WIDTH(DATA_PT_COMB)) u_sum_comb (
        .terms_i (pt_i[DATA_PT_COMB-1:0]),
        .pol_i   (cfg_pol),
        .sum_o   (comb_d)
    );

    mc_out_reg u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (reg_d),
        .q_o   (reg_q)
    );

    // Choose the pin drive, the pin enable and the feedback source for the current form.
    always_comb begin
        pin_o  = 1'b0;
        pin_oe = 1'b0;
        fb_o   = 1'b0;
        unique case (form)
            CELL_REG: begin
                pin_o  = reg_q;
                pin_oe = ~oe_n;
                fb_o   = ~reg_q;
            end
            CELL_COMB: begin
                pin_o  = comb_d;
                pin_oe = pt_i[OE_PT_IDX];
                fb_o   = pin_i;
            end
            default: begin
                pin_o  = 1'b0;
                pin_oe = 1'b0;
                fb_o   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pld_mc_checker.sv
// Module: pld_mc_checker
// Properties of the macrocell, observed only at its ports.
// Assumes: it is bound to pld_reg_macrocell; no check runs while rst_n is low.
module pld_mc_checker #(
    parameter int NUM_PT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              cfg_sync,
    input logic              cfg_ac0,
    input logic              cfg_ac1,
    input logic              cfg_pol,
    input logic [NUM_PT-1:0] pt_i,
    input logic              pin_i,
    input logic              pin_o,
    input logic              pin_oe,
    input logic              fb_o
);

    logic mode_on;
    logic is_reg;
    logic is_comb;

    assign mode_on = !cfg_sync && cfg_ac0;
    assign is_reg  = mode_on && !cfg_ac1;
    assign is_comb = mode_on && cfg_ac1;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |-> (!pin_oe && !pin_o && !fb_o)); // R1

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && is_reg |-> pin_o == ((|$past(pt_i)) ^ !$past(cfg_pol))); // R2

    AST_COMB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        is_comb |-> pin_o == ((|pt_i[NUM_PT-2:0]) ^ !cfg_pol)); // R4

    AST_COMB_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        is_comb |-> pin_oe == pt_i[NUM_PT-1]); // R5

    AST_REG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> pin_oe == !oe_n); // R6

    AST_REG_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        is_reg |-> fb_o == !pin_o); // R7

    AST_COMB_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        is_comb |-> fb_o == pin_i); // R8

endmodule

bind pld_reg_macrocell pld_mc_checker #(.NUM_PT(NUM_PT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .cfg_sync (cfg_sync),
    .cfg_ac0  (cfg_ac0),
    .cfg_ac1  (cfg_ac1),
    .cfg_pol  (cfg_pol),
    .pt_i     (pt_i),
    .pin_i    (pin_i),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe),
    .fb_o     (fb_o)
);

// File: tb/pld_reg_macrocell_tb.sv
// Bench for pld_reg_macrocell: seeded random stimulus plus directed corner cases.
// Inputs change on the falling edge. Outputs are sampled 1 ns later, against a bench model.
`timescale 1ns/1ps
module pld_reg_macrocell_tb_top;

    localparam int NPT = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           oe_n;
    logic           cfg_sync;
    logic           cfg_ac0;
    logic           cfg_ac1;
    logic           cfg_pol;
    logic [NPT-1:0] pt_i;
    logic           pin_i;
    logic           pin_o;
    logic           pin_oe;
    logic           fb_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic q_model  = 1'b0;

    always #5 clk = ~clk;

    pld_reg_macrocell #(.NUM_PT(NPT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .cfg_sync (cfg_sync),
        .cfg_ac0  (cfg_ac0),
        .cfg_ac1  (cfg_ac1),
        .cfg_pol  (cfg_pol),
        .pt_i     (pt_i),
        .pin_i    (pin_i),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe),
        .fb_o     (fb_o)
    );

    // Polarity-adjusted OR of the lowest n terms (R3).
    function automatic logic sum_of(input logic [NPT-1:0] t, input int n, input logic pol);
        logic acc = 1'b0;
        for (int i = 0; i < n; i++) acc |= t[i];
        return pol ? acc : ~acc;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Checks all outputs for the inputs now applied and the modelled flip-flop state.
    task automatic check_outputs();
        logic on = !cfg_sync && cfg_ac0;
        if (!on) begin
            chk("R1 pin_oe", pin_oe, 1'b0);
            chk("R1 pin_o", pin_o, 1'b0);
            chk("R1 fb_o", fb_o, 1'b0);
        end else if (!cfg_ac1) begin
            chk("R2 pin_o", pin_o, q_model);
            chk("R6 pin_oe", pin_oe, !oe_n);
            chk("R7 fb_o", fb_o, !q_model);
        end else begin
            chk("R4 pin_o", pin_o, sum_of(pt_i, NPT - 1, cfg_pol));
            chk("R5 pin_oe", pin_oe, pt_i[NPT-1]);
            chk("R8 fb_o", fb_o, pin_i);
        end
    endtask

    // Waits for one rising edge and updates the flip-flop model (R2, R9).
    task automatic tick();
        logic nxt = rst_n ? sum_of(pt_i, NPT, cfg_pol) : 1'b0;
        @(posedge clk);
        q_model = nxt;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic s, input logic a0, input logic a1, input logic p);
        cfg_sync = s; cfg_ac0 = a0; cfg_ac1 = a1; cfg_pol = p;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; oe_n = 1'b0; pt_i = '1; pin_i = 1'b0;
        set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        tick();
        tick();
        // R9: cleared flip-flop, seen on the registered pin and its feedback.
        chk("R9 pin_o after reset", pin_o, 1'b0);
        chk("R9 fb_o after reset", fb_o, 1'b1);
        rst_n = 1'b1;

        // R2/R3: only term 7 set; the registered sum includes it, under both polarities.
        pt_i = 8'h80; set_cfg(1'b0, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R2 term7 counted, active high", pin_o, 1'b1);
        cfg_pol = 1'b0;
        tick();
        chk("R3 term7 counted, active low", pin_o, 1'b0);

        // R4/R3: combinational form ignores term 7 as data.
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1); #1;
        chk("R4 term7 not data, active high", pin_o, 1'b0);
        chk("R5 term7 enables pin", pin_oe, 1'b1);
        cfg_pol = 1'b0; #1;
        chk("R3 comb active low", pin_o, 1'b1);

        // R10: oe_n toggles with no effect on the combinational pin.
        pt_i = 8'h04; cfg_pol = 1'b1; oe_n = 1'b1; #1;
        chk("R10 oe_n high: pin_oe", pin_oe, 1'b0);
        chk("R10 oe_n high: pin_o", pin_o, 1'b1);
        oe_n = 1'b0; #1;
        chk("R10 oe_n low: pin_oe", pin_oe, 1'b0);
        chk("R10 oe_n low: pin_o", pin_o, 1'b1);

        // R6: the flip-flop keeps loading while oe_n is high.
        @(negedge clk);
        set_cfg(1'b0, 1'b1, 1'b0, 1'b1); pt_i = 8'h00; oe_n = 1'b1;
        tick();
        pt_i = 8'h10;
        #1 chk("R6 disabled pin_oe", pin_oe, 1'b0);
        tick();
        oe_n = 1'b0; #1;
        chk("R6 re-enabled pin_oe", pin_oe, 1'b1);
        chk("R6 data loaded while disabled", pin_o, 1'b1);
        @(negedge clk);

        // Random mix over all mode-bit combinations.
        for (int it = 0; it < 2000; it++) begin
            logic [31:0] r = $urandom();
            set_cfg(r[0], r[1] | r[2], r[3], r[4]);
            oe_n  = r[5];
            pin_i = r[6];
            pt_i  = r[7] ? NPT'($urandom()) : NPT'(r[8] ? (8'h1 << r[11:9]) : 8'h00);
            rst_n = (r[15:12] != 4'd0);
            #1 check_outputs();
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule